// File: doc/BRIEF.md
# Owner-Supplied Snooping Coherence Controller

This block keeps one processor's cache coherent with its peers on a shared, serialising bus. It holds a small direct-mapped array of tags and per-line coherence states and sits between the local processor, which issues read and write requests, and the bus, which it both drives and snoops. Every line is in one of four states: invalid; clean (unmodified, possibly shared, not owned); shared-owned (modified, possibly shared, owned); and exclusive-owned (modified, the only copy, owned). The owning cache, not memory, answers other caches' misses. A read by a peer leaves the owner in shared-owned and does not force a copy back to memory.

The processor holds a request, with a write flag and a block address, until the block pulses `cpu_done`. A read hit, or a write to an exclusive-owned line, finishes without the bus. Any other case asks for the bus with `bus_req`. The transaction goes out in the cycle `bus_gnt` is high and no snooped transaction is present. The local state changes only at that moment. The block issues an invalidate to upgrade a shared copy, a write-miss or read-miss to fetch a block, and a write-back when it evicts an owned line. Every transaction another cache places on the bus is presented on the snoop inputs. The block raises `snp_supply` in that same cycle when it must furnish the data, and it updates the matching line.

Data storage and its timing live outside this block. Only tags, states and bus commands are handled here.

Top module: `coh_snoop_ctrl`

## Requirements
- R1: After reset every line is invalid. `cpu_done`, `bus_req` and `snp_supply` are low, and a snooped read of any block is not supplied.
- R2: A read to a block not present issues one read-miss (bus command code 0) for that block and installs it clean. A second read of it then uses no bus transaction and completes one cycle after the request is presented.
- R3: A write to an exclusive-owned line uses no bus transaction and completes one cycle after the request is presented.
- R4: A write to a clean or shared-owned line issues exactly one invalidate (code 2) for that block and leaves the line exclusive-owned. The next write to it uses no bus transaction.
- R5: A write to a block not present issues one write-miss (code 1) for that block and installs it exclusive-owned.
- R6: A snooped read-miss to a block held shared-owned or exclusive-owned raises `snp_supply` in that cycle and leaves the line shared-owned. A snooped read-miss to a clean line is not supplied and leaves it clean.
- R7: A snooped write-miss or invalidate to a held block makes the line invalid. A write-miss to an owned line is also supplied in that cycle.
- R8: A miss whose slot holds a different block in an owned state first issues a write-back (code 3) carrying the victim's block address, then the fetch for the new block. A clean victim is dropped without any bus transaction. A block address is the tag in its upper 7 bits above the 3-bit slot index.
- R9: A transaction appears on `bus_out_valid` only while `bus_req` and `bus_gnt` are both high and no snooped transaction is present. A snooped transaction in the granted cycle defers the local one.
- R10: While a request waits for the bus, a snooped transaction that hits the line in the requested slot is handled first. The request is then decided anew from the updated state, so a pending upgrade whose copy was invalidated becomes a write-miss.
- R11: `cpu_done` is a single-cycle pulse in the cycle after the completing bus transaction or the local hit decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | Request is a write |
| cpu_blk | input | BLK_W | Requested block address (tag above index) |
| cpu_done | output | 1 | Request completed (one-cycle pulse) |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_out_valid | output | 1 | Local transaction placed on the bus this cycle |
| bus_out_cmd | output | 2 | Command: 0 read-miss, 1 write-miss, 2 invalidate, 3 write-back |
| bus_out_blk | output | BLK_W | Block address of the local transaction |
| snp_valid | input | 1 | A peer's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same codes as `bus_out_cmd` |
| snp_blk | input | BLK_W | Snooped block address |
| snp_supply | output | 1 | This cache furnishes data for the snooped miss |

## Verification
The read and write paths are run from every starting state: invalid, clean, shared-owned and exclusive-owned. The bus traffic they produce tells the state apart: none, an invalidate, a read-miss or write-miss, or a write-back before the fetch. Snooped read-misses, write-misses and invalidates are aimed at owned lines, clean lines and absent lines. The supply flag and the traffic of the next local access show the state each one left behind. A snooped transaction is made to coincide with a grant, showing that it defers the local issue. Another is made to strike a line whose upgrade is still waiting, showing that the request is decided anew rather than sent stale.

// File: rtl/coh_pkg.sv
package coh_pkg;

   typedef enum logic [1:0] {
      LS_INV    = 2'd0,
      LS_CLEAN  = 2'd1,
      LS_OWN_SH = 2'd2,
      LS_OWN_EX = 2'd3
   } line_st_e;

   typedef enum logic [1:0] {
      BC_RDMISS = 2'd0,
      BC_WRMISS = 2'd1,
      BC_KILL   = 2'd2,
      BC_WBACK  = 2'd3
   } bus_cmd_e;

   function automatic logic is_owner(line_st_e s);
      return (s == LS_OWN_SH) || (s == LS_OWN_EX);
   endfunction

endpackage

// File: rtl/coh_tag_array.sv
module coh_tag_array
   import coh_pkg::*;
#(
   parameter int TAG_W = 7,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] ra_idx,
   output logic [TAG_W-1:0] ra_tag,
   output line_st_e         ra_st,
   input  logic [IDX_W-1:0] rb_idx,
   output logic [TAG_W-1:0] rb_tag,
   output line_st_e         rb_st,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  line_st_e         wr_st,
   input  logic             wr_tag_en,
   input  logic [TAG_W-1:0] wr_tag
);

   localparam int LINES = 1 << IDX_W;

   logic [LINES*2-1:0]     st_flat;
   logic [LINES*TAG_W-1:0] tag_flat;

   for (genvar i = 0; i < LINES; i++) begin : g_line
      line_st_e         st_r;
      logic [TAG_W-1:0] tag_r;
      logic             sel;

      assign sel = wr_en && (wr_idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_r  <= LS_INV;
            tag_r <= '0;
         end else if (sel) begin
            st_r <= wr_st;
            if (wr_tag_en) tag_r <= wr_tag;
         end
      end

      assign st_flat[i*2 +: 2]          = st_r;
      assign tag_flat[i*TAG_W +: TAG_W] = tag_r;
   end

   assign ra_st  = line_st_e'(st_flat[{ra_idx, 1'b0} +: 2]);
   assign ra_tag = tag_flat[ra_idx*TAG_W +: TAG_W];
   assign rb_st  = line_st_e'(st_flat[{rb_idx, 1'b0} +: 2]);
   assign rb_tag = tag_flat[rb_idx*TAG_W +: TAG_W];

endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
   import coh_pkg::*;
#(
   parameter int TAG_W = 7
) (
   input  logic             snp_valid,
   input  bus_cmd_e         snp_cmd,
   input  logic [TAG_W-1:0] snp_tag,
   input  logic [TAG_W-1:0] slot_tag,
   input  line_st_e         slot_st,
   output logic             hit,
   output logic             supply,
   output logic             upd_en,
   output line_st_e         upd_st
);

   logic owned;

   assign hit   = snp_valid && (slot_st != LS_INV) && (slot_tag == snp_tag);
   assign owned = is_owner(slot_st);

   always_comb begin
      supply = 1'b0;
      upd_en = 1'b0;
      upd_st = slot_st;
      if (hit) begin
         unique case (snp_cmd)
            BC_RDMISS: begin
               supply = owned;
               upd_en = (slot_st == LS_OWN_EX);
               upd_st = LS_OWN_SH;
            end
            BC_WRMISS: begin
               supply = owned;
               upd_en = 1'b1;
               upd_st = LS_INV;
            end
            BC_KILL: begin
               upd_en = 1'b1;
               upd_st = LS_INV;
            end
            default: begin
               upd_en = 1'b0;
            end
         endcase
      end
   end

endmodule

// File: rtl/coh_req_fsm.sv
module coh_req_fsm
   import coh_pkg::*;
#(
   parameter int TAG_W = 7,
   parameter int IDX_W = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cpu_req,
   input  logic                   cpu_we,
   input  logic [TAG_W-1:0]       cpu_tag,
   input  logic [IDX_W-1:0]       cpu_idx,
   input  logic [TAG_W-1:0]       lk_tag,
   input  line_st_e               lk_st,
   input  logic                   snp_valid,
   input  logic                   snp_slot_hit,
   input  logic                   bus_gnt,
   output logic                   bus_req,
   output logic                   bus_out_valid,
   output bus_cmd_e               bus_out_cmd,
   output logic [TAG_W+IDX_W-1:0] bus_out_blk,
   output logic                   cpu_done,
   output logic                   upd_en,
   output line_st_e               upd_st,
   output logic                   upd_tag_en
);

   typedef enum logic [2:0] {
      F_IDLE  = 3'd0,
      F_WBACK = 3'd1,
      F_FETCH = 3'd2,
      F_UPGR  = 3'd3,
      F_DONE  = 3'd4
   } fsm_e;

   fsm_e state_q, state_d;
   logic hit, issue;

   assign hit   = (lk_st != LS_INV) && (lk_tag == cpu_tag);
   assign issue = bus_req && bus_gnt && !snp_valid;

   always_comb begin
      bus_req     = 1'b0;
      bus_out_cmd = BC_RDMISS;
      bus_out_blk = {cpu_tag, cpu_idx};
      upd_en      = 1'b0;
      upd_st      = LS_INV;
      upd_tag_en  = 1'b0;
      unique case (state_q)
         F_WBACK: begin
            bus_req     = 1'b1;
            bus_out_cmd = BC_WBACK;
            bus_out_blk = {lk_tag, cpu_idx};
            upd_en      = issue;
            upd_st      = LS_INV;
         end
         F_FETCH: begin
            bus_req     = 1'b1;
            bus_out_cmd = cpu_we ? BC_WRMISS : BC_RDMISS;
            upd_en      = issue;
            upd_st      = cpu_we ? LS_OWN_EX : LS_CLEAN;
            upd_tag_en  = 1'b1;
         end
         F_UPGR: begin
            bus_req     = 1'b1;
            bus_out_cmd = BC_KILL;
            upd_en      = issue;
            upd_st      = LS_OWN_EX;
         end
         default: begin
            bus_req = 1'b0;
         end
      endcase
   end

   assign bus_out_valid = issue;
   assign cpu_done      = (state_q == F_DONE);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         F_IDLE: begin
            if (cpu_req && !snp_slot_hit) begin
               if (hit && (!cpu_we || lk_st == LS_OWN_EX)) state_d = F_DONE;
               else if (hit)                               state_d = F_UPGR;
               else if (is_owner(lk_st))                   state_d = F_WBACK;
               else                                        state_d = F_FETCH;
            end
         end
         F_WBACK, F_FETCH, F_UPGR: begin
            if (snp_slot_hit)                  state_d = F_IDLE;
            else if (issue && state_q == F_WBACK) state_d = F_FETCH;
            else if (issue)                    state_d = F_DONE;
         end
         default: state_d = F_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= F_IDLE;
      else        state_q <= state_d;
   end

endmodule

// File: rtl/coh_snoop_ctrl.sv
module coh_snoop_ctrl
   import coh_pkg::*;
#(
   parameter  int TAG_W = 7,
   parameter  int IDX_W = 3,
   localparam int BLK_W = TAG_W + IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_req,
   input  logic             cpu_we,
   input  logic [BLK_W-1:0] cpu_blk,
   output logic             cpu_done,
   output logic             bus_req,
   input  logic             bus_gnt,
   output logic             bus_out_valid,
   output logic [1:0]       bus_out_cmd,
   output logic [BLK_W-1:0] bus_out_blk,
   input  logic             snp_valid,
   input  logic [1:0]       snp_cmd,
   input  logic [BLK_W-1:0] snp_blk,
   output logic             snp_supply
);

   if (TAG_W < 1) begin : g_bad_tag
      $error("coh_snoop_ctrl: TAG_W must be at least 1");
   end
   if (IDX_W < 1 || IDX_W > 10) begin : g_bad_idx
      $error("coh_snoop_ctrl: IDX_W must lie in 1..10");
   end

   logic [TAG_W-1:0] cpu_tag, snp_tag, lk_tag, sl_tag;
   logic [IDX_W-1:0] cpu_idx, snp_idx;
   line_st_e         lk_st, sl_st;

   assign cpu_tag = cpu_blk[BLK_W-1:IDX_W];
   assign cpu_idx = cpu_blk[IDX_W-1:0];
   assign snp_tag = snp_blk[BLK_W-1:IDX_W];
   assign snp_idx = snp_blk[IDX_W-1:0];

   logic     sn_hit, sn_upd_en;
   line_st_e sn_upd_st;
   logic     fs_upd_en, fs_tag_en;
   line_st_e fs_upd_st;
   bus_cmd_e fs_cmd;

   logic             wr_en, wr_tag_en;
   logic [IDX_W-1:0] wr_idx;
   line_st_e         wr_st;

   // Snoop updates win the single write port; the request FSM only
   // writes when it issues, which it never does beside a snoop.
   assign wr_en     = sn_upd_en || fs_upd_en;
   assign wr_idx    = sn_upd_en ? snp_idx   : cpu_idx;
   assign wr_st     = sn_upd_en ? sn_upd_st : fs_upd_st;
   assign wr_tag_en = !sn_upd_en && fs_tag_en;

   coh_tag_array #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
      .clk       (clk),
      .rst_n     (rst_n),
      .ra_idx    (cpu_idx),
      .ra_tag    (lk_tag),
      .ra_st     (lk_st),
      .rb_idx    (snp_idx),
      .rb_tag    (sl_tag),
      .rb_st     (sl_st),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_st     (wr_st),
      .wr_tag_en (wr_tag_en),
      .wr_tag    (cpu_tag)
   );

   coh_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
      .snp_valid (snp_valid),
      .snp_cmd   (bus_cmd_e'(snp_cmd)),
      .snp_tag   (snp_tag),
      .slot_tag  (sl_tag),
      .slot_st   (sl_st),
      .hit       (sn_hit),
      .supply    (snp_supply),
      .upd_en    (sn_upd_en),
      .upd_st    (sn_upd_st)
   );

   coh_req_fsm #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .cpu_req       (cpu_req),
      .cpu_we        (cpu_we),
      .cpu_tag       (cpu_tag),
      .cpu_idx       (cpu_idx),
      .lk_tag        (lk_tag),
      .lk_st         (lk_st),
      .snp_valid     (snp_valid),
      .snp_slot_hit  (sn_hit && (snp_idx == cpu_idx)),
      .bus_gnt       (bus_gnt),
      .bus_req       (bus_req),
      .bus_out_valid (bus_out_valid),
      .bus_out_cmd   (fs_cmd),
      .bus_out_blk   (bus_out_blk),
      .cpu_done      (cpu_done),
      .upd_en        (fs_upd_en),
      .upd_st        (fs_upd_st),
      .upd_tag_en    (fs_tag_en)
   );

   assign bus_out_cmd = fs_cmd;

endmodule

// File: rtl/coh_snoop_ctrl_chk.sv
module coh_snoop_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cpu_req,
   input logic       cpu_done,
   input logic       bus_req,
   input logic       bus_gnt,
   input logic       bus_out_valid,
   input logic [1:0] bus_out_cmd,
   input logic       snp_valid,
   input logic [1:0] snp_cmd,
   input logic       snp_supply
);

   // R9
   issue_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_out_valid |-> (bus_req && bus_gnt && !snp_valid));

   // R6
   supply_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snp_supply |-> (snp_valid && (snp_cmd == 2'd0 || snp_cmd == 2'd1)));

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |=> !cpu_done);

   // R11
   done_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |-> $past(cpu_req));

   // R4
   kill_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_out_valid && bus_out_cmd == 2'd2) |=> cpu_done);

   // R8
   wback_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_out_valid && bus_out_cmd == 2'd3) |=> (bus_req && !cpu_done));

endmodule

bind coh_snoop_ctrl coh_snoop_ctrl_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cpu_req       (cpu_req),
   .cpu_done      (cpu_done),
   .bus_req       (bus_req),
   .bus_gnt       (bus_gnt),
   .bus_out_valid (bus_out_valid),
   .bus_out_cmd   (bus_out_cmd),
   .snp_valid     (snp_valid),
   .snp_cmd       (snp_cmd),
   .snp_supply    (snp_supply)
);

// File: tb/tb_coh_snoop_ctrl.sv
module tb_coh_snoop_ctrl;

   localparam int TAG_W = 7;
   localparam int IDX_W = 3;
   localparam int BLK_W = TAG_W + IDX_W;

   localparam logic [1:0] C_RD = 2'd0, C_WR = 2'd1, C_KILL = 2'd2, C_WB = 2'd3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cpu_req = 1'b0, cpu_we = 1'b0;
   logic [BLK_W-1:0] cpu_blk = '0;
   logic             cpu_done, bus_req, bus_gnt, bus_out_valid, snp_supply;
   logic [1:0]       bus_out_cmd;
   logic [BLK_W-1:0] bus_out_blk;
   logic             snp_valid = 1'b0;
   logic [1:0]       snp_cmd = 2'd0;
   logic [BLK_W-1:0] snp_blk = '0;
   logic             hold = 1'b0;

   always #4 clk = ~clk;
   assign bus_gnt = bus_req && !hold;

   coh_snoop_ctrl #(.TAG_W(TAG_W), .IDX_W(IDX_W)) dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_blk(cpu_blk), .cpu_done(cpu_done),
      .bus_req(bus_req), .bus_gnt(bus_gnt),
      .bus_out_valid(bus_out_valid), .bus_out_cmd(bus_out_cmd), .bus_out_blk(bus_out_blk),
      .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_blk(snp_blk), .snp_supply(snp_supply)
   );

   typedef struct {
      logic [1:0]       cmd;
      logic [BLK_W-1:0] blk;
      string            why;
   } txn_t;

   txn_t exp_q[$];
   int   checks = 0;
   int   fails  = 0;

   task automatic check_eq(input string why, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", why, act, exp);
      end
   endtask

   function automatic logic [BLK_W-1:0] mk(input int tag, input int idx);
      return {TAG_W'(tag), IDX_W'(idx)};
   endfunction

   task automatic expect_txn(input logic [1:0] c, input logic [BLK_W-1:0] b, input string why);
      txn_t t;
      t.cmd = c; t.blk = b; t.why = why;
      exp_q.push_back(t);
   endtask

   // monitor: pops the scoreboard as transactions appear
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rst_n && bus_out_valid) begin
            if (exp_q.size() == 0) begin
               check_eq("R9 unexpected bus transaction cmd", int'(bus_out_cmd), -1);
            end else begin
               txn_t t;
               t = exp_q.pop_front();
               check_eq({t.why, " cmd"}, int'(bus_out_cmd), int'(t.cmd));
               check_eq({t.why, " blk"}, int'(bus_out_blk), int'(t.blk));
            end
         end
      end
   end

   int  op_lat;
   bit  op_fin;

   task automatic cpu_op(input bit we, input logic [BLK_W-1:0] b, input string why);
      int lat;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_blk = b;
      lat = 0;
      do begin
         @(negedge clk);
         #1;
         lat++;
      end while (!cpu_done && lat < 500);
      cpu_req = 1'b0;
      op_lat = lat;
      check_eq({why, " R11 done seen"}, int'(cpu_done), 1);
      @(negedge clk);
      #1;
      check_eq({why, " R11 done single cycle"}, int'(cpu_done), 0);
      check_eq({why, " scoreboard drained"}, exp_q.size(), 0);
   endtask

   task automatic snoop(input logic [1:0] c, input logic [BLK_W-1:0] b,
                        input int exp_sup, input string why);
      @(negedge clk);
      snp_valid = 1'b1; snp_cmd = c; snp_blk = b;
      #1;
      check_eq(why, int'(snp_supply), exp_sup);
      @(negedge clk);
      snp_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [BLK_W-1:0] a, b, c, d, e, f;
      a = mk(1, 0); b = mk(2, 0); c = mk(3, 0);
      d = mk(1, 1); e = mk(5, 2); f = mk(9, 3);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check_eq("R1 cpu_done after reset", int'(cpu_done), 0);
      check_eq("R1 bus_req after reset", int'(bus_req), 0);
      check_eq("R1 snp_supply after reset", int'(snp_supply), 0);
      snoop(C_RD, a, 0, "R1 snooped read of empty line not supplied");

      // R2: miss from invalid, then hit
      expect_txn(C_RD, a, "R2 read miss");
      cpu_op(1'b0, a, "R2 read miss");
      cpu_op(1'b0, a, "R2 read hit");
      check_eq("R2 read hit latency", op_lat, 1);
      snoop(C_RD, a, 0, "R6 snooped read of clean line not supplied");

      // R4 from clean, then R3
      expect_txn(C_KILL, a, "R4 upgrade from clean");
      cpu_op(1'b1, a, "R4 write hit clean");
      cpu_op(1'b1, a, "R3 write hit owned-exclusive");
      check_eq("R3 write hit latency", op_lat, 1);
      snoop(C_RD, a, 1, "R6 snooped read of owned line supplied");
      snoop(C_RD, a, 1, "R6 shared-owned still supplies");
      expect_txn(C_KILL, a, "R4 upgrade from shared-owned");
      cpu_op(1'b1, a, "R4 write hit shared-owned");

      // R8: owned victim written back, clean victim silent
      expect_txn(C_WB, a, "R8 write-back of owned victim");
      expect_txn(C_RD, b, "R8 fetch after write-back");
      cpu_op(1'b0, b, "R8 owned eviction");
      expect_txn(C_RD, c, "R8 clean victim dropped silently");
      cpu_op(1'b0, c, "R8 clean eviction");

      // R5 and R7
      expect_txn(C_WR, d, "R5 write miss");
      cpu_op(1'b1, d, "R5 write miss");
      cpu_op(1'b1, d, "R5 line now owned-exclusive");
      check_eq("R5 hit latency after write miss", op_lat, 1);
      snoop(C_WR, d, 1, "R7 snooped write miss on owned line supplied");
      expect_txn(C_RD, d, "R7 line invalid after snooped write miss");
      cpu_op(1'b0, d, "R7 reread after write miss");
      snoop(C_KILL, d, 0, "R7 snooped invalidate not supplied");
      expect_txn(C_RD, d, "R7 line invalid after snooped invalidate");
      cpu_op(1'b0, d, "R7 reread after invalidate");

      // R10: pending upgrade struck by a remote invalidate
      hold = 1'b1;
      op_fin = 1'b0;
      fork
         begin
            cpu_op(1'b1, d, "R10 restarted write");
            op_fin = 1'b1;
         end
      join_none
      repeat (3) @(negedge clk);
      #1;
      check_eq("R10 request waiting for bus", int'(bus_req), 1);
      snoop(C_KILL, d, 0, "R10 invalidate while waiting");
      expect_txn(C_WR, d, "R10 upgrade turned into write miss");
      hold = 1'b0;
      wait (op_fin);
      cpu_op(1'b1, d, "R10 line owned-exclusive after restart");
      check_eq("R10 hit latency after restart", op_lat, 1);

      // R9: snooped transaction in the granted cycle defers the issue
      hold = 1'b1;
      op_fin = 1'b0;
      expect_txn(C_WR, e, "R9 deferred write miss");
      fork
         begin
            cpu_op(1'b1, e, "R9 deferred write");
            op_fin = 1'b1;
         end
      join_none
      repeat (3) @(negedge clk);
      hold = 1'b0;
      snp_valid = 1'b1; snp_cmd = C_RD; snp_blk = f;
      #1;
      check_eq("R9 grant present with snoop", int'(bus_gnt), 1);
      check_eq("R9 no issue beside snoop", int'(bus_out_valid), 0);
      check_eq("R6 absent block not supplied", int'(snp_supply), 0);
      @(negedge clk);
      snp_valid = 1'b0;
      wait (op_fin);

      repeat (2) @(negedge clk);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule